// File: doc/BRIEF.md
# Manchester Word Transmitter with Sync Prefix

This block turns a parallel word from a host processor into one serial frame for a bus transceiver. A frame lasts 20 bit times. It opens with a three-bit-time sync prefix whose polarity marks the word as a command/status word or a data word. The data bits follow in Manchester code, and a parity bit closes the frame. The transceiver driver is enabled only while a frame is being sent. Each bit cell is split into two half-cells, and a half-cell counter times them. With the default of 8 clocks per half-cell and a 16 MHz clock, the line rate is 1 Mb/s.

The host offers words through a ready/valid handshake. When the transmitter is idle, an offered word is taken at once and its sync starts on the next clock. While a frame is in flight, the transmitter takes the next word only during that frame's parity cell. That word's sync then follows the parity cell with no gap, so a whole message of consecutive words streams without a break. When no word is waiting at the end of a frame, the transmitter returns to idle, reasserts inhibit and drives both line outputs low.

The controller has four states. `ST_IDLE` waits for a word. `ST_SYNC` emits the six sync half-cells. `ST_DATA` emits two half-cells per data bit. `ST_PARITY` emits the parity cell and accepts the next word. The transitions are: IDLE to SYNC when a word is available; SYNC to DATA after the sixth half-cell; DATA to PARITY after the last data half-cell; PARITY to SYNC when a word is waiting at the end of the cell; PARITY to IDLE when none is waiting.

Top module: `mwt_word_tx`

## Requirements
- R1: After reset, `tx_inhibit` is 1, `tx_pos` and `tx_neg` are 0, `in_ready` is 1, and `busy` and `done` are 0.
- R2: A word accepted while idle starts its frame on the next clock. The frame lasts 40 half-cells of HALF_CYC clocks each (320 clocks by default), and `tx_inhibit` stays 0 throughout.
- R3: The sync prefix is six half-cells long. With `in_is_cmd`=1, `tx_pos` is high for the first three half-cells and low for the next three; with `in_is_cmd`=0 the pattern is inverted.
- R4: Data bits go out most significant bit first, one bit per two half-cells. A 1 is sent as high then low on `tx_pos`, and a 0 as low then high.
- R5: The last two half-cells carry an odd parity bit over the data word, Manchester coded like a data bit. The bit is 1 when the word has an even number of ones.
- R6: While `tx_inhibit` is 0, `tx_neg` is the complement of `tx_pos`. While `tx_inhibit` is 1, both are 0. `tx_pos` changes only at half-cell boundaries.
- R7: `in_ready` is 1 when idle, and during the parity cell while no word is waiting. It is 0 during sync and data. A word held on the input while `in_ready` is 0 is not taken and is never transmitted.
- R8: If a word is accepted during the parity cell, its sync starts on the clock right after the last parity half-cell, and `tx_inhibit` stays 0 across the boundary.
- R9: If no word is waiting at the end of the parity cell, then on the next clock `tx_inhibit` returns to 1 and both line outputs are 0.
- R10: `busy` is 1 on every cycle of a frame. `done` pulses for exactly one cycle, the last cycle of each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; HALF_CYC clocks make one half-cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Transmitter can take a word this cycle |
| in_data | input | WORD_W | Word to transmit |
| in_is_cmd | input | 1 | 1 selects the command/status sync, 0 the data sync |
| tx_pos | output | 1 | True line output toward the transceiver |
| tx_neg | output | 1 | Complementary line output |
| tx_inhibit | output | 1 | 1 disables the transceiver driver |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse on the last cycle of a frame |

## Verification
Assertions in the RTL check the line discipline on every cycle: the outputs are complementary while driving and quiet while inhibited, and `tx_pos` holds steady inside a half-cell. They also check three moves of the controller: idle to sync after an accept, parity to sync when a word is waiting, and parity to idle when none is. One more assertion checks that a waiting word is never overwritten. Only the bench's scenarios can show the content of each frame: the sync polarity for each word type, the bit order, the parity value for words with odd and even numbers of ones, gap-free streaming of several words, and that a word offered during sync or data is never sent.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_DATA   = 2'd2,
        ST_PARITY = 2'd3
    } tx_state_e;

    localparam int SYNC_HALVES   = 6;
    localparam int SYNC_HIGH_LEN = 3;
    localparam int PAR_HALVES    = 2;
endpackage

// File: rtl/mwt_halfcell_timer.sv
module mwt_halfcell_timer #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic first_cyc,
    output logic cell_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cell_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cell_end  = run && (cnt_q == LAST);
        first_cyc = (cnt_q == '0);
    end

    // The count never passes the last clock of a half-cell (R2 timing).
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // A stopped timer always restarts from zero (R2).
    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> first_cyc);
endmodule

// File: rtl/mwt_stage.sv
module mwt_stage #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_cmd,
    output logic              pend_v,
    output logic              nxt_v,
    output logic [WORD_W-1:0] nxt_data,
    output logic              nxt_cmd,
    output logic              nxt_par
);
    logic [WORD_W-1:0] hold_data_q;
    logic              hold_cmd_q;
    logic              hold_v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v_q    <= 1'b0;
            hold_data_q <= '0;
            hold_cmd_q  <= 1'b0;
        end else if (pop) begin
            hold_v_q <= 1'b0;
        end else if (push) begin
            hold_v_q    <= 1'b1;
            hold_data_q <= in_data;
            hold_cmd_q  <= in_cmd;
        end
    end

    // A held word has priority; otherwise the input bypasses the slot.
    always_comb begin
        pend_v   = hold_v_q;
        nxt_v    = hold_v_q || push;
        nxt_data = hold_v_q ? hold_data_q : in_data;
        nxt_cmd  = hold_v_q ? hold_cmd_q : in_cmd;
        nxt_par  = ~(^nxt_data);
    end

    // A waiting word is never overwritten by a new one (R7).
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v_q && !pop) |-> !push);
endmodule

// File: rtl/mwt_encoder.sv
module mwt_encoder #(
    parameter int HW = 5
) (
    input  mwt_pkg::tx_state_e state,
    input  logic [HW-1:0]      hidx,
    input  logic               is_cmd,
    input  logic               msb,
    input  logic               par,
    output logic               level
);
    import mwt_pkg::*;

    always_comb begin
        unique case (state)
            ST_IDLE:   level = 1'b0;
            ST_SYNC:   level = is_cmd ? (hidx <  HW'(SYNC_HIGH_LEN))
                                      : (hidx >= HW'(SYNC_HIGH_LEN));
            ST_DATA:   level = hidx[0] ? ~msb : msb;
            ST_PARITY: level = hidx[0] ? ~par : par;
            default:   level = 1'b0;
        endcase
    end
endmodule

// File: rtl/mwt_word_tx.sv
module mwt_word_tx #(
    parameter int WORD_W   = 16,
    parameter int HALF_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_is_cmd,
    output logic              tx_pos,
    output logic              tx_neg,
    output logic              tx_inhibit,
    output logic              busy,
    output logic              done
);
    import mwt_pkg::*;

    localparam int HW = $clog2(2 * WORD_W);
    localparam logic [HW-1:0] SYNC_LAST = HW'(SYNC_HALVES - 1);
    localparam logic [HW-1:0] DATA_LAST = HW'(2 * WORD_W - 1);
    localparam logic [HW-1:0] PAR_LAST  = HW'(PAR_HALVES - 1);

    tx_state_e         state_q, state_d;
    logic [HW-1:0]     hidx_q, hidx_d;
    logic [WORD_W-1:0] cur_word_q;
    logic              cur_cmd_q;
    logic              cur_par_q;

    logic              active;
    logic              cell_end;
    logic              first_cyc;
    logic              frame_end;
    logic              push;
    logic              pop;
    logic              pend_v;
    logic              nxt_v;
    logic [WORD_W-1:0] nxt_data;
    logic              nxt_cmd;
    logic              nxt_par;
    logic              level;

    assign active    = (state_q != ST_IDLE);
    assign frame_end = (state_q == ST_PARITY) && cell_end && (hidx_q == PAR_LAST);
    assign push      = in_valid && in_ready;
    assign pop       = nxt_v && ((state_q == ST_IDLE) || frame_end);

    mwt_halfcell_timer #(.HALF_CYC(HALF_CYC)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .first_cyc (first_cyc),
        .cell_end  (cell_end)
    );

    mwt_stage #(.WORD_W(WORD_W)) i_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .in_data  (in_data),
        .in_cmd   (in_is_cmd),
        .pend_v   (pend_v),
        .nxt_v    (nxt_v),
        .nxt_data (nxt_data),
        .nxt_cmd  (nxt_cmd),
        .nxt_par  (nxt_par)
    );

    mwt_encoder #(.HW(HW)) i_enc (
        .state  (state_q),
        .hidx   (hidx_q),
        .is_cmd (cur_cmd_q),
        .msb    (cur_word_q[WORD_W-1]),
        .par    (cur_par_q),
        .level  (level)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        hidx_d  = hidx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (nxt_v) begin
                    state_d = ST_SYNC;
                    hidx_d  = '0;
                end
            end
            ST_SYNC: begin
                if (cell_end) begin
                    if (hidx_q == SYNC_LAST) begin
                        state_d = ST_DATA;
                        hidx_d  = '0;
                    end else begin
                        hidx_d = hidx_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (cell_end) begin
                    if (hidx_q == DATA_LAST) begin
                        state_d = ST_PARITY;
                        hidx_d  = '0;
                    end else begin
                        hidx_d = hidx_q + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (cell_end) begin
                    if (hidx_q == PAR_LAST) begin
                        state_d = nxt_v ? ST_SYNC : ST_IDLE;
                        hidx_d  = '0;
                    end else begin
                        hidx_d = hidx_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                hidx_d  = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hidx_q  <= '0;
        end else begin
            state_q <= state_d;
            hidx_q  <= hidx_d;
        end
    end

    // Word register: loaded on pop, shifted after each odd data half-cell.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_word_q <= '0;
            cur_cmd_q  <= 1'b0;
            cur_par_q  <= 1'b0;
        end else if (pop) begin
            cur_word_q <= nxt_data;
            cur_cmd_q  <= nxt_cmd;
            cur_par_q  <= nxt_par;
        end else if ((state_q == ST_DATA) && cell_end && hidx_q[0]) begin
            cur_word_q <= {cur_word_q[WORD_W-2:0], 1'b0};
        end
    end

    // Output logic.
    always_comb begin
        tx_inhibit = !active;
        tx_pos     = active && level;
        tx_neg     = active && !level;
        busy       = active;
        in_ready   = (state_q == ST_IDLE) || ((state_q == ST_PARITY) && !pend_v);
        done       = frame_end;
    end

    // R6: both line outputs are quiet while inhibited.
    assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> (!tx_pos && !tx_neg));

    // R6: the outputs are complementary while driving.
    assert_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_inhibit |-> (tx_pos != tx_neg));

    // R6: the line level holds steady inside a half-cell.
    assert_halfcell_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !first_cyc) |-> $stable(tx_pos));

    // R2: a word offered while idle starts a frame on the next clock.
    assert_start_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid) |=> (state_q == ST_SYNC && !tx_inhibit));

    // R8: a waiting word chains straight into a new sync.
    assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && nxt_v) |=> (state_q == ST_SYNC && hidx_q == '0 && !tx_inhibit));

    // R9: with nothing waiting, the driver is released after the frame.
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !nxt_v) |=> tx_inhibit);

    // R7: no word is taken during sync or data.
    assert_no_take_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC || state_q == ST_DATA) |-> !in_ready);
endmodule

// File: tb/test_mwt_word_tx.sv
module test_mwt_word_tx;
    localparam int WORD_W   = 16;
    localparam int HALF_CYC = 8;
    localparam int HALVES   = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [WORD_W-1:0] in_data = '0;
    logic              in_is_cmd = 1'b0;
    logic              tx_pos, tx_neg, tx_inhibit, busy, done;

    always #2 clk = ~clk;

    mwt_word_tx #(.WORD_W(WORD_W), .HALF_CYC(HALF_CYC)) i_mwt_word_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_is_cmd(in_is_cmd), .tx_pos(tx_pos),
        .tx_neg(tx_neg), .tx_inhibit(tx_inhibit), .busy(busy), .done(done)
    );

    typedef struct {
        logic [HALVES-1:0] pat;
        bit                chained;
        logic [WORD_W-1:0] w;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   words_sent = 0;
    int   done_seen = 0;
    bit   mon_active = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [HALVES-1:0] build(input logic [WORD_W-1:0] w, input logic cmd);
        logic [HALVES-1:0] p;
        logic              par;
        par = ~(^w);
        for (int i = 0; i < 3; i++) begin
            p[i]     = cmd;
            p[i + 3] = ~cmd;
        end
        for (int b = 0; b < WORD_W; b++) begin
            p[6 + 2*b] = w[WORD_W-1-b];
            p[7 + 2*b] = ~w[WORD_W-1-b];
        end
        p[38] = par;
        p[39] = ~par;
        return p;
    endfunction

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Driver: offers a word, records the expected frame at acceptance.
    task automatic send(input logic [WORD_W-1:0] w, input logic cmd);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = w;
        in_is_cmd = cmd;
        while (!in_ready) @(negedge clk);
        e.pat     = build(w, cmd);
        e.chained = busy;
        e.w       = w;
        q.push_back(e);
        words_sent++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0 || mon_active || !tx_inhibit) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // Monitor: compares each half-cell against the expected pattern.
    task automatic watch_frames();
        bit more;
        more = 1'b1;
        while (more) begin
            exp_t e;
            mon_active = 1'b1;
            if (q.size() == 0) begin
                chk(1'b0, "R7 unexpected frame", 32'd1, 32'd0);
                e.pat = '0;
                e.w   = '0;
            end else begin
                e = q.pop_front();
            end
            for (int k = 0; k < HALVES; k++) begin
                repeat ((k == 0) ? 4 : HALF_CYC) @(negedge clk);
                if (k < 6)
                    chk(tx_pos == e.pat[k], "R3 sync", {31'd0, tx_pos}, {31'd0, e.pat[k]});
                else if (k < 38)
                    chk(tx_pos == e.pat[k], "R4 data", {31'd0, tx_pos}, {31'd0, e.pat[k]});
                else
                    chk(tx_pos == e.pat[k], "R5 parity", {31'd0, tx_pos}, {31'd0, e.pat[k]});
                chk(!tx_inhibit, "R2 inhibit low", {31'd0, tx_inhibit}, 32'd0);
                chk(tx_neg == ~tx_pos, "R6 complement", {31'd0, tx_neg}, {31'd0, ~tx_pos});
                chk(busy, "R10 busy", {31'd0, busy}, 32'd1);
                if (k < 38)
                    chk(!in_ready, "R7 ready low", {31'd0, in_ready}, 32'd0);
            end
            repeat (4) @(negedge clk);
            if (q.size() > 0 && q[0].chained) begin
                chk(!tx_inhibit, "R8 no gap", {31'd0, tx_inhibit}, 32'd0);
            end else begin
                chk(tx_inhibit && !tx_pos && !tx_neg, "R9 release",
                    {29'd0, tx_inhibit, tx_pos, tx_neg}, 32'd4);
                more = 1'b0;
            end
        end
        mon_active = 1'b0;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !tx_inhibit) watch_frames();
        end
    end

    always @(negedge clk) begin
        if (rst_n && done) done_seen++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd1, 32'd0);
        summary_and_end();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(tx_inhibit == 1'b1, "R1 inhibit", {31'd0, tx_inhibit}, 32'd1);
        chk(!tx_pos && !tx_neg, "R1 line", {30'd0, tx_pos, tx_neg}, 32'd0);
        chk(in_ready == 1'b1, "R1 ready", {31'd0, in_ready}, 32'd1);
        chk(!busy && !done, "R1 busy/done", {30'd0, busy, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Single words from idle: command sync and data sync, several parities.
        send(16'hA5C3, 1'b1);
        wait_idle();
        send(16'h0000, 1'b0);
        wait_idle();
        send(16'h0001, 1'b1);
        wait_idle();

        // R8: streamed message of three words with no gaps.
        send(16'h8001, 1'b1);
        send(16'h7FFE, 1'b0);
        send(16'hFFFF, 1'b0);
        wait_idle();

        // R7: a word held during sync/data and withdrawn is never sent.
        send(16'h1234, 1'b1);
        repeat (30) @(negedge clk);
        in_valid  = 1'b1;
        in_data   = 16'hDEAD;
        in_is_cmd = 1'b0;
        repeat (40) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        chk(tx_inhibit && !tx_pos && !tx_neg, "R7 offer ignored",
            {29'd0, tx_inhibit, tx_pos, tx_neg}, 32'd4);

        // R10: one done pulse per frame.
        chk(done_seen == words_sent, "R10 done count", done_seen, words_sent);
        summary_and_end();
    end
endmodule